// File: doc/BRIEF.md
# Tuning-Word Serial Register Slave

This block is the serial control front end of a frequency synthesiser. A host talks to it over a two-wire I2C bus at up to 400 kHz. It writes the divider and control settings of a phase-locked loop and reads back one status byte. The block samples the bus clock and data lines with a much faster system clock. It finds START and STOP conditions and the bus clock edges from those samples, and it pulls SDA low through an open-drain enable output.

A write carries the slave address followed by any mix of data bytes. The first bit of a fresh data byte decides its kind. A 0 starts a frequency pair and a 1 marks the first control byte. The two frequency bytes reach the divider outputs together, and only once the second byte has arrived. A transfer cut short leaves the previous settings in force. A read returns a status byte that holds a power-up flag, the loop lock flag and a 3-bit converter code. The power-up flag clears itself once it has been sent.

Top module: `tune_reg_slave`

## Requirements
- R1: The slave answers only the address byte 1,1,0,0,0,addrSel[1],addrSel[0],rw (MSB first; rw=0 write, rw=1 read). On any other address it leaves SDA released and ignores every byte until the next START.
- R2: After a matching address and after every data byte of a write, the slave drives SDA low in the acknowledge slot (ACK observed as 0).
- R3: A data byte with MSB 0, when no frequency byte is pending, holds M10..M4 in its low 7 bits. The next byte holds M3..M0 in bits 7:4 and the swallow count in bits 3:0, whatever its MSB. All 11 divider bits and the swallow count update together after that second byte. A pair left incomplete by a STOP changes nothing.
- R4: A data byte with MSB 1 that is not a second frequency byte or a second control byte is the first control byte. Its bit 6 sets mainRatio[12], bit 5 sets mainRatio[11], bit 4 sets prescEn and bits 3:0 set refCode, and all of these take effect at once.
- R5: The byte right after a first control byte is the second control byte, whatever its MSB. Its bit 7 sets varicapOff, bit 6 sets cpHigh and bits 3:0 set portBits.
- R6: A repeated START with a new address is accepted without a STOP. It discards any half-received frequency pair.
- R7: In a read the slave sends the status byte MSB first: power-up flag, lockFlag, 1, 1, 1, convCode[2:0].
- R8: The power-up flag is 1 after reset. It is 0 in every status byte sent after a complete status byte has gone out.
- R9: After reset every tuning output is 0.
- R10: After a status byte, a master ACK (SDA low) makes the slave send the status byte again. A master NACK makes it release SDA until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| sclIn | input | 1 | Bus clock line as sampled at the pad |
| sdaIn | input | 1 | Bus data line as sampled at the pad |
| sdaOe | output | 1 | 1 pulls the data line low |
| addrSel | input | 2 | Variable low address bits |
| lockFlag | input | 1 | Loop lock indication for the status byte |
| convCode | input | 3 | Converter code for the status byte |
| mainRatio | output | 13 | Main divider ratio M |
| swallow | output | 4 | Swallow count S |
| prescEn | output | 1 | Adds the extra divide-by-two prescaler |
| refCode | output | 4 | Reference divider selection |
| varicapOff | output | 1 | Turns the tuning-voltage output off |
| cpHigh | output | 1 | Selects the higher charge-pump current |
| portBits | output | 4 | General output port levels |

## Verification
The assertions assume that the bus levels change far more slowly than the system clock. Each SCL phase must last several clock cycles longer than the synchroniser and edge detector take. SDA must change only while SCL is low, except to signal START or STOP. Under those conditions the acknowledge and release checks tie the internal strobes to SDA exactly one cycle later. The bench drives every bus phase for ten system clocks. It changes SDA a full quarter bit after an SCL fall. It changes lockFlag, convCode and addrSel only while the bus is idle.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAIN_W    = 13;
  localparam int SWAL_W    = 4;
  localparam int REF_W     = 4;
  localparam int PORT_W    = 4;
  localparam int CONV_W    = 3;
  localparam int SEL_W     = 2;
  localparam int FREQ_HI_W = BYTE_W - 1;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam logic [BYTE_W-SEL_W-2:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic txnStart;
    logic shiftIn;
    logic wrByte;
    logic loadTx;
    logic shiftTx;
    logic porClr;
  } tuneStrb_t;
endpackage

// File: rtl/tune_bus_ctrl.sv
module tune_bus_ctrl
  import tune_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [SEL_W-1:0]    addrSel,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic                txMsb,
  output tuneStrb_t           strb,
  output logic                sdaBit,
  output logic                sdaOe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic gotByte, rwBit, mNack, addrMatch;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
  assign addrMatch = (rxByte[BYTE_W-1:1] == {ADDR_FIXED, addrSel});

  always_comb begin
    strb = '0;
    strb.txnStart = startEv;
    strb.shiftIn  = sclRise && (state == ST_ADDR || state == ST_WDATA);
    strb.wrByte   = sclFall && state == ST_WDATA && gotByte;
    strb.loadTx   = sclFall && ((state == ST_ADDR_ACK && rwBit) || (state == ST_RACK && !mNack));
    strb.shiftTx  = sclFall && state == ST_RDATA && bitCnt != LAST_BIT;
    strb.porClr   = sclFall && state == ST_RDATA && bitCnt == LAST_BIT;
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WACK) || (state == ST_RDATA && !txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      gotByte <= 1'b0;
      rwBit   <= 1'b0;
      mNack   <= 1'b1;
    end else if (startEv) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      gotByte <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) gotByte <= 1'b1;
          end else if (sclFall && gotByte) begin
            gotByte <= 1'b0;
            bitCnt  <= '0;
            if (state == ST_WDATA) begin
              state <= ST_WACK;
            end else if (addrMatch) begin
              state <= ST_ADDR_ACK;
              rwBit <= rxByte[0];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          state  <= rwBit ? ST_RDATA : ST_WDATA;
          bitCnt <= '0;
        end
        ST_WACK: if (sclFall) state <= ST_WDATA;
        ST_RDATA: if (sclFall) begin
          if (bitCnt == LAST_BIT) begin
            state  <= ST_RACK;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_RACK: begin
          if (sclRise) mNack <= sdaS;
          else if (sclFall) state <= mNack ? ST_IGNORE : ST_RDATA;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tune_regs.sv
module tune_regs
  import tune_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tuneStrb_t          strb,
  input  logic               sdaBit,
  input  logic               lockFlag,
  input  logic [CONV_W-1:0]  convCode,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               txMsb,
  output logic [MAIN_W-1:0]  mainRatio,
  output logic [SWAL_W-1:0]  swallow,
  output logic               prescEn,
  output logic [REF_W-1:0]   refCode,
  output logic               varicapOff,
  output logic               cpHigh,
  output logic [PORT_W-1:0]  portBits
);
  localparam int LOW_W = FREQ_HI_W + BYTE_W - SWAL_W;

  logic [BYTE_W-1:0]    txShift;
  logic [FREQ_HI_W-1:0] pairHi;
  logic pairPend, ctl2Next, porFlag;
  logic [BYTE_W-1:0] statusByte;

  assign statusByte = {porFlag, lockFlag, 3'b111, convCode};
  assign txMsb = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '1;
      porFlag <= 1'b1;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (strb.loadTx) txShift <= statusByte;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      else if (strb.porClr) begin
        txShift <= '1;
        porFlag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairHi     <= '0;
      pairPend   <= 1'b0;
      ctl2Next   <= 1'b0;
      mainRatio  <= '0;
      swallow    <= '0;
      prescEn    <= 1'b0;
      refCode    <= '0;
      varicapOff <= 1'b0;
      cpHigh     <= 1'b0;
      portBits   <= '0;
    end else if (strb.txnStart) begin
      pairPend <= 1'b0;
      ctl2Next <= 1'b0;
    end else if (strb.wrByte) begin
      if (ctl2Next) begin
        varicapOff <= rxByte[7];
        cpHigh     <= rxByte[6];
        portBits   <= rxByte[PORT_W-1:0];
        ctl2Next   <= 1'b0;
      end else if (pairPend) begin
        mainRatio[LOW_W-1:0] <= {pairHi, rxByte[BYTE_W-1:SWAL_W]};
        swallow  <= rxByte[SWAL_W-1:0];
        pairPend <= 1'b0;
      end else if (rxByte[BYTE_W-1]) begin
        mainRatio[MAIN_W-1:LOW_W] <= rxByte[6:5];
        prescEn  <= rxByte[4];
        refCode  <= rxByte[REF_W-1:0];
        ctl2Next <= 1'b1;
      end else begin
        pairHi   <= rxByte[FREQ_HI_W-1:0];
        pairPend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tune_reg_slave.sv
module tune_reg_slave
  import tune_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [SEL_W-1:0]   addrSel,
  input  logic               lockFlag,
  input  logic [CONV_W-1:0]  convCode,
  output logic [MAIN_W-1:0]  mainRatio,
  output logic [SWAL_W-1:0]  swallow,
  output logic               prescEn,
  output logic [REF_W-1:0]   refCode,
  output logic               varicapOff,
  output logic               cpHigh,
  output logic [PORT_W-1:0]  portBits
);
  tuneStrb_t ctrlStr;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb, sdaBit;

  tune_bus_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rxByte(rxByte), .txMsb(txMsb), .strb(ctrlStr), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  tune_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(ctrlStr), .sdaBit(sdaBit), .lockFlag(lockFlag),
    .convCode(convCode), .rxByte(rxByte), .txMsb(txMsb), .mainRatio(mainRatio),
    .swallow(swallow), .prescEn(prescEn), .refCode(refCode), .varicapOff(varicapOff),
    .cpHigh(cpHigh), .portBits(portBits)
  );
endmodule

// File: rtl/tune_reg_slave_chk.sv
module tune_reg_slave_chk
  import tune_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic [SWAL_W-1:0] swallow,
  input logic [REF_W-1:0]  refCode,
  input logic              wrByte,
  input logic              loadTx,
  input logic              txnStart,
  input logic              shiftTx
);
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrByte |=> sdaOe);

  p_start_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    txnStart |=> !sdaOe);

  p_pair_only_on_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swallow) |-> $past(wrByte));

  p_ctl_only_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refCode) |-> $past(wrByte));

  p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrByte, loadTx, txnStart, shiftTx}));
endmodule

bind tune_reg_slave tune_reg_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .swallow(swallow), .refCode(refCode),
  .wrByte(ctrlStr.wrByte), .loadTx(ctrlStr.loadTx), .txnStart(ctrlStr.txnStart),
  .shiftTx(ctrlStr.shiftTx)
);

// File: tb/tb_tune_reg_slave.sv
`timescale 1ns/1ps
module tb_tune_reg_slave;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] addrSel = 2'b10;
  logic lockFlag = 1'b1;
  logic [2:0] convCode = 3'b101;
  wire sdaOe;
  wire sdaLine = sdaDrv & ~sdaOe;
  wire [12:0] mainRatio;
  wire [3:0] swallow, refCode, portBits;
  wire prescEn, varicapOff, cpHigh;

  tune_reg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .lockFlag(lockFlag), .convCode(convCode),
    .mainRatio(mainRatio), .swallow(swallow), .prescEn(prescEn), .refCode(refCode),
    .varicapOff(varicapOff), .cpHigh(cpHigh), .portBits(portBits)
  );

  typedef struct { bit kind; string req; logic [31:0] exp; } item_t;
  item_t q[$];
  logic [31:0] obsVal;
  event chkEv;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  function automatic logic [31:0] mk(logic [12:0] m, logic [3:0] s, logic pe,
                                     logic [3:0] r, logic os, logic cp, logic [3:0] p);
    return {4'b0, m, s, pe, r, os, cp, p};
  endfunction

  function automatic logic [31:0] regsNow();
    return mk(mainRatio, swallow, prescEn, refCode, varicapOff, cpHigh, portBits);
  endfunction

  // scoreboard monitor
  initial forever begin
    item_t it;
    logic [31:0] act;
    @(chkEv);
    @(negedge clk);
    while (q.size() > 0) begin
      it = q.pop_front();
      act = it.kind ? obsVal : regsNow();
      nChecks++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic expectRegs(string r, logic [31:0] e);
    q.push_back('{1'b0, r, e});
    ->chkEv;
    repeat (3) @(negedge clk);
  endtask

  task automatic expectObs(string r, logic [31:0] got, logic [31:0] e);
    obsVal = got;
    q.push_back('{1'b1, r, e});
    ->chkEv;
    repeat (3) @(negedge clk);
  endtask

  task automatic qtr();
    repeat (10) @(negedge clk);
  endtask

  task automatic startC();
    sdaDrv = 1'b1; qtr(); sclDrv = 1'b1; qtr();
    sdaDrv = 1'b0; qtr(); sclDrv = 1'b0; qtr();
  endtask

  task automatic stopC();
    sdaDrv = 1'b0; qtr(); sclDrv = 1'b1; qtr(); sdaDrv = 1'b1; qtr();
  endtask

  task automatic sendBit(bit b);
    sdaDrv = b; qtr(); sclDrv = 1'b1; qtr(); qtr(); sclDrv = 1'b0; qtr();
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaDrv = 1'b1; qtr(); sclDrv = 1'b1; qtr();
    ack = sdaLine; qtr(); sclDrv = 1'b0; qtr();
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; qtr(); sclDrv = 1'b1; qtr();
      b[i] = sdaLine; qtr(); sclDrv = 1'b0; qtr();
    end
  endtask

  // send a byte the slave must acknowledge
  task automatic wb(string r, logic [7:0] b);
    bit a;
    sendByte(b, a);
    expectObs(r, {31'b0, a}, 32'd0);
  endtask

  task automatic readOnce(string r, logic [7:0] e);
    logic [7:0] b;
    startC();
    wb("R2 read address ack", 8'hC5);
    recvByte(b);
    sendBit(1'b1);
    stopC();
    expectObs(r, {24'b0, b}, {24'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b1, b2;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    expectRegs("R9 reset outputs", 32'd0);

    // first read: power-up flag set, lock 1, code 101
    readOnce("R7 R8 first status", 8'hFD);
    lockFlag = 1'b0; convCode = 3'b010;
    readOnce("R8 flag cleared after read", 8'h3A);

    // full five-byte write; second frequency byte has MSB 1
    startC();
    wb("R1 R2 write address", 8'hC4);
    wb("R2 freq1", 8'h35);
    wb("R2 freq2", 8'hA7);
    wb("R2 ctl1", 8'hD9);
    wb("R2 ctl2", 8'h8B);
    stopC();
    expectRegs("R3 R4 R5 full write", mk(13'h135A, 4'h7, 1'b1, 4'h9, 1'b1, 1'b0, 4'hB));

    // partial: only first frequency byte
    startC();
    wb("R2 address", 8'hC4);
    wb("R2 lone freq1", 8'h12);
    stopC();
    expectRegs("R3 partial pair ignored", mk(13'h135A, 4'h7, 1'b1, 4'h9, 1'b1, 1'b0, 4'hB));

    // three-byte frequency write
    startC();
    wb("R2 address", 8'hC4);
    wb("R2 freq1", 8'h01);
    wb("R2 freq2", 8'h5F);
    stopC();
    expectRegs("R3 pair write", mk(13'h1015, 4'hF, 1'b1, 4'h9, 1'b1, 1'b0, 4'hB));

    // wrong address: no ack, data ignored
    startC();
    sendByte(8'hC0, a);
    expectObs("R1 mismatch no ack", {31'b0, a}, 32'd1);
    sendByte(8'h22, a);
    expectObs("R1 ignored byte no ack", {31'b0, a}, 32'd1);
    sendByte(8'h33, a);
    stopC();
    expectRegs("R1 mismatch keeps regs", mk(13'h1015, 4'hF, 1'b1, 4'h9, 1'b1, 1'b0, 4'hB));

    // repeated start drops pending half pair
    startC();
    wb("R2 address", 8'hC4);
    wb("R2 freq1 pending", 8'h40);
    startC();
    wb("R6 address after repeated start", 8'hC4);
    wb("R6 freq1", 8'h02);
    wb("R6 freq2", 8'h31);
    wb("R4 ctl1", 8'h80);
    wb("R5 ctl2 msb0", 8'h41);
    stopC();
    expectRegs("R6 R5 repeated start", mk(13'h0023, 4'h1, 1'b0, 4'h0, 1'b0, 1'b1, 4'h1));

    // other address select, control byte 1 alone
    addrSel = 2'b01;
    qtr();
    startC();
    wb("R1 alt address", 8'hC2);
    wb("R4 ctl1 alone", 8'hFF);
    stopC();
    expectRegs("R4 ctl1 immediate", mk(13'h1823, 4'h1, 1'b1, 4'hF, 1'b0, 1'b1, 4'h1));

    // read twice in one transfer with master ack
    addrSel = 2'b10; lockFlag = 1'b1; convCode = 3'b000;
    qtr();
    startC();
    wb("R2 read address", 8'hC5);
    recvByte(b1);
    sendBit(1'b0);
    recvByte(b2);
    sendBit(1'b1);
    qtr();
    expectObs("R10 released after nack", {31'b0, sdaOe}, 32'd0);
    stopC();
    expectObs("R10 first status", {24'b0, b1}, 32'h78);
    expectObs("R10 repeated status", {24'b0, b2}, 32'h78);

    repeat (20) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule